// File: doc/BRIEF.md
# Multi-Lane Serial Configuration Streamer

This block loads the configuration bitstreams of several programmable target devices at once. It fetches 16-bit words from a word-addressed memory and spreads each word over 1, 2, 4 or 8 DATA lines. A data-clock strobe runs alongside the lines. Each lane feeds one target device or one daisy chain. The streams are stored bit-interleaved, so that every group of n bits in a word holds one bit for each lane. The widest setting also works as a parallel byte port: one whole byte leaves on the eight lines per strobe.

A start strobe captures three things: the lane mode, the first word address and the stream length in 4-bit nibbles. The block then issues sequential word reads and keeps one word prefetched. It toggles the strobe once per external clock-enable tick, changing the lines only when the strobe falls. When the nibble budget is used up, it raises a one-cycle done flag. Shorter per-device streams must be padded by whoever packs the memory. A lane without a device still shifts along with the others.

Top module: `cfg_streamer`

## Requirements
- R1: `mode_i` selects the lane count n: 2'b00 gives 1 lane, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. Each strobe consumes the next n bits of the current word, starting from bit 0. Lane k (`data_o[k]`) carries bit k of that n-bit group.
- R2: Words are read from consecutive addresses, beginning at `start_addr_i`. `mem_data_i` is taken as valid in the cycle after `mem_rd_o` is high. Each read lasts one cycle.
- R3: One run produces exactly ceil(4*len/n) rising edges of `dclk_o`, where len is `len_nib_i`.
- R4: `data_o` is held stable when `dclk_o` rises and for as long as `dclk_o` stays high. It may change only in the cycle where `dclk_o` falls.
- R5: Lanes k >= n are driven 0. Outside a run, `dclk_o` and all of `data_o` are 0.
- R6: In mode 2'b11, strobe j carries byte j of the stream on `data_o[7:0]`. Within each word, the low byte comes first.
- R7: `done_o` is high for exactly one cycle, in the cycle where the final falling edge of `dclk_o` appears. In that cycle `busy_o` is low and `data_o` is 0.
- R8: A start request made while `busy_o` is high is ignored. The running stream completes unchanged.
- R9: A start with a length of 0 raises `done_o` in the next cycle. It does not raise `busy_o` and produces no strobe.
- R10: `dclk_o` changes level only on cycles where `tick_i` is high, one level change per tick.
- R11: After reset, `busy_o`, `done_o`, `dclk_o`, `mem_rd_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable; each tick is one half period of the strobe |
| mode_i | input | 2 | Lane mode (see R1), captured at start |
| start_i | input | 1 | Start request |
| start_addr_i | input | ADDR_W | Word address of the first word |
| len_nib_i | input | LEN_W | Stream length in nibbles |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_data_i | input | WORD_W | Read data, valid one cycle after the request |
| data_o | output | 8 | DATA lanes |
| dclk_o | output | 1 | Data clock strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Streams are run in every lane mode from different start addresses and at several tick rates. Each captured lane bit is compared with the bit that the interleaving rule selects from the stored words. A wrong group order, a wrong lane order or a wrong word sequence therefore shows up as a bit mismatch rather than as a wrong count. The 8-lane run uses an odd nibble count and a tick on every cycle. This separates correct rounding of the strobe count from an off-by-one, and it puts the prefetch under its tightest timing. The byte-wise parallel run, the start request made mid-run and the zero-length start each isolate one ordering or control path. A slow tick rate confirms that the strobe's high time follows the tick spacing.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int unsigned LANES = 8;

  typedef enum logic [1:0] {
    LANES_1 = 2'd0,
    LANES_2 = 2'd1,
    LANES_4 = 2'd2,
    LANES_8 = 2'd3
  } lane_mode_e;

  function automatic logic [3:0] lane_count(lane_mode_e m);
    return 4'd1 << m;
  endfunction
endpackage

// File: rtl/cfg_word_fetch.sv
module cfg_word_fetch #(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              req_i,
  input  logic              take_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [WORD_W-1:0] buf_o,
  output logic              buf_vld_o
);
  logic              rd_q, cap_q, vld_q;
  logic [ADDR_W-1:0] addr_q, next_q;
  logic [WORD_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      cap_q  <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      next_q <= '0;
      buf_q  <= '0;
    end else begin
      cap_q <= rd_q;
      if (load_i) begin
        addr_q <= start_addr_i;
        next_q <= start_addr_i + 1'b1;
        rd_q   <= 1'b1;
      end else if (req_i) begin
        addr_q <= next_q;
        next_q <= next_q + 1'b1;
        rd_q   <= 1'b1;
      end else begin
        rd_q <= 1'b0;
      end
      // one-cycle read latency: data lands the cycle after the request
      if (cap_q) begin
        buf_q <= mem_data_i;
        vld_q <= 1'b1;
      end else if (take_i || load_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign mem_rd_o   = rd_q;
  assign mem_addr_o = addr_q;
  assign buf_o      = buf_q;
  assign buf_vld_o  = vld_q;

  p_single_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && !req_i && !load_i) |=> !rd_q);
  p_no_overrun_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |-> !vld_q);
  p_no_underrun_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> vld_q);
endmodule

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
  import cfg_stream_pkg::*;
#(
  parameter int unsigned N_LANES = LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  lane_mode_e         mode_i,
  input  logic               active_i,
  input  logic [N_LANES-1:0] grp_i,
  output logic [N_LANES-1:0] data_o
);
  logic [3:0] n_act;
  assign n_act = lane_count(mode_i);

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    assign data_o[k] = active_i && (4'(k) < n_act) && grp_i[k];
  end

  p_unused_lane_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != LANES_8) |-> (data_o >> n_act) == '0);
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_stream_pkg::*;
#(
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned LEN_W  = 25,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        mode_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  len_nib_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic [LANES-1:0]  data_o,
  output logic              dclk_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned REM_W = LEN_W + 2;
  localparam int unsigned GRP_W = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_RUN} state_e;

  state_e            state_q;
  lane_mode_e        mode_q;
  logic [REM_W-1:0]  rem_q;
  logic [GRP_W-1:0]  grp_q;
  logic [WORD_W-1:0] sh_q, buf_w;
  logic              dclk_q, done_q, buf_vld;
  logic              load, take, fall, last_pulse, last_grp;
  logic [REM_W-1:0]  n_bits;

  assign n_bits     = REM_W'(lane_count(mode_q));
  assign fall       = (state_q == ST_RUN) && tick_i && dclk_q;
  assign last_pulse = rem_q <= n_bits;
  assign last_grp   = grp_q == GRP_W'((WORD_W >> mode_q) - 1);
  assign load       = (state_q == ST_IDLE) && start_i && (len_nib_i != '0);
  assign take       = ((state_q == ST_PRIME) && buf_vld) ||
                      (fall && !last_pulse && last_grp);

  cfg_word_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
    .clk_i, .rst_ni,
    .load_i      (load),
    .start_addr_i(start_addr_i),
    .req_i       (take),
    .take_i      (take),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_data_i),
    .buf_o       (buf_w),
    .buf_vld_o   (buf_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= LANES_1;
      rem_q   <= '0;
      grp_q   <= '0;
      sh_q    <= '0;
      dclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (len_nib_i == '0) done_q <= 1'b1;
          else begin
            mode_q  <= lane_mode_e'(mode_i);
            rem_q   <= {len_nib_i, 2'b00};
            state_q <= ST_PRIME;
          end
        end
        ST_PRIME: if (buf_vld) begin
          sh_q    <= buf_w;
          grp_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: if (tick_i) begin
          if (!dclk_q) dclk_q <= 1'b1;
          else begin
            dclk_q <= 1'b0;
            if (last_pulse) begin
              rem_q   <= '0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              rem_q <= rem_q - n_bits;
              if (last_grp) begin
                sh_q  <= buf_w;
                grp_q <= '0;
              end else begin
                sh_q  <= sh_q >> lane_count(mode_q);
                grp_q <= grp_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cfg_lane_map #(.N_LANES(LANES)) u_lanes (
    .clk_i, .rst_ni,
    .mode_i  (mode_q),
    .active_i(state_q == ST_RUN),
    .grp_i   (sh_q[LANES-1:0]),
    .data_o  (data_o)
  );

  assign dclk_o = dclk_q;
  assign busy_o = state_q != ST_IDLE;
  assign done_o = done_q;

  p_rise_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> $stable(data_o));
  p_high_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |=> ($stable(data_o) || !dclk_o));
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dclk_o && data_o == '0));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mode_q));
  p_tick_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(dclk_o));
endmodule

// File: tb/cfg_streamer_bench.sv
module cfg_streamer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 23;
  localparam int LEN_W  = 25;
  localparam int WORD_W = 16;

  logic clk = 0, rst_ni = 0, tick_i = 0, start_i = 0;
  logic [1:0] mode_i = 0;
  logic [ADDR_W-1:0] start_addr_i = 0;
  logic [LEN_W-1:0] len_nib_i = 0;
  logic mem_rd_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [WORD_W-1:0] mem_data_i = 0;
  logic [7:0] data_o;
  logic dclk_o, busy_o, done_o;

  cfg_streamer u_cfg_streamer (
    .clk_i(clk), .rst_ni, .tick_i, .mode_i, .start_i, .start_addr_i, .len_nib_i,
    .mem_rd_o, .mem_addr_o, .mem_data_i, .data_o, .dclk_o, .busy_o, .done_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem [64];
  always_ff @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o[5:0]];

  int n_chk = 0, n_fail = 0, cyc = 0, tdiv = 1, tcnt = 0;
  logic [7:0] cap [512];
  int cap_n = 0, hi_cnt = 0, first_hi = -1, rise_busy_low = 0;
  logic dclk_prev = 0;

  always @(negedge clk) begin
    cyc++;
    if (tcnt >= tdiv - 1) begin tcnt = 0; tick_i = 1; end
    else begin tcnt++; tick_i = 0; end
    if (dclk_o && !dclk_prev) begin
      if (cap_n < 512) cap[cap_n] = data_o;
      cap_n++;
      hi_cnt = 0;
    end
    if (dclk_o) hi_cnt++;
    if (!dclk_o && dclk_prev && first_hi < 0) first_hi = hi_cnt;
    dclk_prev = dclk_o;
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
    report();
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(int base, int j, int n, int k);
    int b;
    if (k >= n) return 1'b0;
    b = j * n + k;
    return mem[(base + b / 16) % 64][b % 16];
  endfunction

  task automatic kick(int mode, int addr, int len);
    @(negedge clk);
    mode_i = mode[1:0]; start_addr_i = ADDR_W'(addr); len_nib_i = LEN_W'(len);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done_o && t < 20000) begin @(negedge clk); t++; end
    check({req, " done seen"}, done_o, 1);
    check({req, " done quiet"}, {busy_o, dclk_o, data_o}, 0);
    @(negedge clk);
    check("R7 done one cycle", done_o, 0);
  endtask

  task automatic run_stream(string req, int mode, int addr, int len, int div,
                            int inject);
    int n, exp_p, bad, bad_unused;
    n = 1 << mode;
    tdiv = div; cap_n = 0; first_hi = -1;
    kick(mode, addr, len);
    if (inject) begin
      repeat (6) @(negedge clk);
      start_i = 1; mode_i = 2'd0; len_nib_i = 20; start_addr_i = 0; // R8
      @(negedge clk); start_i = 0;
    end
    wait_done(req);
    exp_p = (4 * len + n - 1) / n;
    check({req, " R3 pulse count"}, cap_n, exp_p);
    bad = 0; bad_unused = 0;
    for (int j = 0; j < exp_p && j < cap_n; j++)
      for (int k = 0; k < 8; k++) begin
        if (cap[j][k] !== exp_bit(addr, j, n, k)) begin
          if (k >= n) bad_unused++; else bad++;
        end
      end
    check({req, " R1 R2 lane bits mismatches"}, bad, 0);
    check({req, " R5 unused lanes nonzero"}, bad_unused, 0);
  endtask

  task automatic t_reset;
    check("R11 reset outputs", {busy_o, done_o, dclk_o, mem_rd_o, data_o}, 0);
  endtask

  task automatic t_parallel_bytes;
    int bad = 0;
    run_stream("R6 8-lane even", 3, 40, 16, 2, 0);
    for (int j = 0; j < 8; j++)
      if (cap[j] !== mem[40 + j / 2][8 * (j % 2) +: 8]) bad++;
    check("R6 byte order mismatches", bad, 0);
  endtask

  task automatic t_tick_rate;
    run_stream("R10 4-lane slow", 2, 20, 16, 3, 0);
    check("R10 high phase cycles", first_hi, 3);
  endtask

  task automatic t_zero_len;
    int seen_busy = 0, pulses;
    tdiv = 1; pulses = cap_n;
    @(negedge clk);
    len_nib_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    check("R9 done next cycle", done_o, 1);
    check("R9 no busy", busy_o, 0);
    repeat (4) begin @(negedge clk); if (busy_o) seen_busy++; end
    check("R9 busy never", seen_busy, 0);
    check("R9 no strobe", cap_n, pulses);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'((i * 40503) ^ (i << 7) ^ 16'h5A3C);
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    run_stream("R1 1-lane", 0, 3, 8, 2, 0);
    run_stream("R1 2-lane", 1, 10, 12, 1, 0);
    t_tick_rate();
    run_stream("R3 8-lane odd", 3, 30, 9, 1, 0);
    t_parallel_bytes();
    run_stream("R8 busy start", 2, 5, 8, 1, 1);
    t_zero_len();
    report();
  end
endmodule